// File: doc/BRIEF.md
# Sectored Posted-Write Buffer

This block stores posted memory writes that arrive from a bridge's originating bus and forwards them to the destination-side bus master. Incoming write beats carry a byte address, a data word, byte enables, an end-of-transaction flag and a command code. Each beat is placed in a fixed 128-byte sector of an on-chip ring. A sector is sealed when the beat at the last word of its 128-byte address window is written, or when the beat that ends the incoming transaction is written. A sealed sector becomes a burst request to the destination sequencer.

The destination side uses a simple handshake. The block raises a request with a start address and a command, and holds them until a grant arrives. It then presents data beats one at a time, and the sequencer takes each one with a ready strobe. When a burst reaches the end of a sector, it runs on into the next sector of the ring only if that sector is already sealed and still belongs to the same write. Otherwise the burst ends there.

When the destination is flagged as conventional, the block rewrites the block-write command into the plain memory-write command. Only the two memory-write codes are buffered. Every other command is taken from the input and dropped.

Top module: `posted_wr_buf`

## Requirements
- R1: After reset, req_o and beat_valid_o are low and in_ready_o is high.
- R2: A sector is sealed on a beat whose word offset (address bits 6:2) is 31, or on a beat with in_last_i set. Each sealed sector leads to a request whose req_addr_o is the byte address of the first beat stored in that sector.
- R3: At the last beat of a sector, the burst goes on without a gap into the next ring sector only if two things hold: the current sector was not sealed by in_last_i, and the next sector is already sealed. Otherwise beat_last_o is high on that beat, and the rest of the write follows as a new request.
- R4: Command 4'hF is sent as 4'h7 when dst_conv_i is 1 and passed through unchanged when dst_conv_i is 0. Command 4'h7 is always sent as 4'h7.
- R5: Beats whose command is neither 4'h7 nor 4'hF (for example I/O write 4'h3 or configuration write 4'hB) are accepted with in_ready_o high and never produce a request.
- R6: in_ready_o is low when a memory-write beat needs a fresh sector and every sector of the ring is occupied. The beat is taken once the drain frees a sector.
- R7: Data and byte enables of each beat reach beat_data_o and beat_be_o unchanged. This includes all-zero enables, which give fully masked bytes.
- R8: Sectors are issued in arrival order. Two incoming transactions never share a burst, so the final beat of each transaction carries beat_last_o.
- R9: req_o, req_addr_o and req_cmd_o hold steady until gnt_i. Each data beat holds steady until beat_ready_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dst_conv_i | input | 1 | Destination bus is in conventional mode |
| in_valid_i | input | 1 | Incoming write beat valid |
| in_ready_o | output | 1 | Incoming beat accepted |
| in_addr_i | input | 32 | Byte address of the beat (word aligned) |
| in_data_i | input | 32 | Beat data |
| in_be_i | input | 4 | Beat byte enables |
| in_last_i | input | 1 | Beat ends the incoming transaction |
| in_cmd_i | input | 4 | Incoming command code |
| req_o | output | 1 | Burst request to destination sequencer |
| req_addr_o | output | 32 | Burst start byte address |
| req_cmd_o | output | 4 | Translated command |
| gnt_i | input | 1 | Request granted |
| beat_valid_o | output | 1 | Outgoing data beat valid |
| beat_ready_i | input | 1 | Outgoing beat taken |
| beat_data_o | output | 32 | Outgoing data |
| beat_be_o | output | 4 | Outgoing byte enables |
| beat_last_o | output | 1 | Final beat of the burst |

## Verification
The forwarding path is exercised with several kinds of write, and each one separates a different failure. A single beat shows that in_last_i seals a sector. A full aligned sector shows sealing at offset 31. A write that starts in mid-sector and crosses a boundary shows that the offset and base are kept, and a two-sector write tells continuation apart from a split burst. A write that stops exactly at a boundary with no end flag, followed later by its remainder, checks that a burst does not run into an unsealed sector. Back-to-back contiguous writes show that transactions are never merged. Dropped I/O and configuration codes, a full ring that stalls the input, and both settings of the conventional-mode flag complete the set.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam logic [3:0] CMD_IO_WR      = 4'h3;
  localparam logic [3:0] CMD_MEM_WR     = 4'h7;
  localparam logic [3:0] CMD_CFG_WR     = 4'hB;
  localparam logic [3:0] CMD_MEM_WR_BLK = 4'hF;

  typedef enum logic [1:0] {DR_IDLE, DR_REQ, DR_DATA} drain_st_e;

  function automatic logic is_posted(logic [3:0] cmd);
    return (cmd == CMD_MEM_WR) || (cmd == CMD_MEM_WR_BLK);
  endfunction

  function automatic logic [3:0] xlate_cmd(logic [3:0] cmd, logic conv);
    return (conv && cmd == CMD_MEM_WR_BLK) ? CMD_MEM_WR : cmd;
  endfunction
endpackage

// File: rtl/pwb_store.sv
module pwb_store #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [BE_W-1:0]   wr_be_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [BE_W-1:0]   rd_be_o
);
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [BE_W-1:0]   be_q   [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      data_q[wr_idx_i] <= wr_data_i;
      be_q[wr_idx_i]   <= wr_be_i;
    end
  end

  assign rd_data_o = data_q[rd_idx_i];
  assign rd_be_o   = be_q[rd_idx_i];
endmodule

// File: rtl/pwb_fill.sv
module pwb_fill import pwb_pkg::*; #(
  parameter int NUM_SECT = 4,
  parameter int BEATS    = 32,
  parameter int HI_W     = 25,
  localparam int OFF_W   = $clog2(BEATS),
  localparam int SP_W    = $clog2(NUM_SECT)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          in_valid_i,
  input  logic [HI_W+OFF_W-1:0]         in_waddr_i,
  input  logic                          in_last_i,
  input  logic [3:0]                    in_cmd_i,
  output logic                          in_ready_o,
  output logic                          wr_en_o,
  output logic [SP_W+OFF_W-1:0]         wr_idx_o,
  input  logic                          release_i,
  input  logic [SP_W-1:0]               release_sect_i,
  output logic [NUM_SECT-1:0]           sect_occ_o,
  output logic [NUM_SECT-1:0]           sect_closed_o,
  output logic [NUM_SECT-1:0]           sect_tail_o,
  output logic [NUM_SECT-1:0][OFF_W-1:0] sect_start_o,
  output logic [NUM_SECT-1:0][OFF_W-1:0] sect_end_o,
  output logic [NUM_SECT-1:0][HI_W-1:0]  sect_base_o,
  output logic [NUM_SECT-1:0][3:0]       sect_cmd_o
);
  logic [SP_W-1:0]  wr_ptr_q;
  logic             filling_q;
  logic [OFF_W-1:0] off;
  logic             posted, acc, closing;

  assign off        = in_waddr_i[OFF_W-1:0];
  assign posted     = is_posted(in_cmd_i);
  assign in_ready_o = !posted || filling_q || !sect_occ_o[wr_ptr_q];
  assign acc        = in_valid_i && in_ready_o && posted;
  assign closing    = in_last_i || (off == OFF_W'(BEATS - 1));
  assign wr_en_o    = acc;
  assign wr_idx_o   = {wr_ptr_q, off};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q      <= '0;
      filling_q     <= 1'b0;
      sect_occ_o    <= '0;
      sect_closed_o <= '0;
      sect_tail_o   <= '0;
      sect_start_o  <= '0;
      sect_end_o    <= '0;
      sect_base_o   <= '0;
      sect_cmd_o    <= '0;
    end else begin
      if (release_i) begin
        sect_occ_o[release_sect_i]    <= 1'b0;
        sect_closed_o[release_sect_i] <= 1'b0;
      end
      if (acc) begin
        if (!filling_q) begin
          sect_occ_o[wr_ptr_q]   <= 1'b1;
          sect_start_o[wr_ptr_q] <= off;
          sect_base_o[wr_ptr_q]  <= in_waddr_i[HI_W+OFF_W-1:OFF_W];
          sect_cmd_o[wr_ptr_q]   <= in_cmd_i;
        end
        sect_end_o[wr_ptr_q] <= off;
        if (closing) begin
          sect_closed_o[wr_ptr_q] <= 1'b1;
          sect_tail_o[wr_ptr_q]   <= in_last_i;
          wr_ptr_q                <= wr_ptr_q + SP_W'(1);
          filling_q               <= 1'b0;
        end else begin
          filling_q <= 1'b1;
        end
      end
    end
  end

  AST_OPEN_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filling_q |-> sect_occ_o[wr_ptr_q] && !sect_closed_o[wr_ptr_q]); // R2
  AST_RELEASE_SEALED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |-> sect_closed_o[release_sect_i]); // R8
endmodule

// File: rtl/pwb_drain.sv
module pwb_drain import pwb_pkg::*; #(
  parameter int NUM_SECT = 4,
  parameter int BEATS    = 32,
  parameter int HI_W     = 25,
  parameter int BYTE_W   = 2,
  localparam int OFF_W   = $clog2(BEATS),
  localparam int SP_W    = $clog2(NUM_SECT),
  localparam int ADDR_W  = HI_W + OFF_W + BYTE_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          dst_conv_i,
  input  logic [NUM_SECT-1:0]           sect_occ_i,
  input  logic [NUM_SECT-1:0]           sect_closed_i,
  input  logic [NUM_SECT-1:0]           sect_tail_i,
  input  logic [NUM_SECT-1:0][OFF_W-1:0] sect_start_i,
  input  logic [NUM_SECT-1:0][OFF_W-1:0] sect_end_i,
  input  logic [NUM_SECT-1:0][HI_W-1:0]  sect_base_i,
  input  logic [NUM_SECT-1:0][3:0]       sect_cmd_i,
  output logic                          req_o,
  output logic [ADDR_W-1:0]             req_addr_o,
  output logic [3:0]                    req_cmd_o,
  input  logic                          gnt_i,
  output logic                          beat_valid_o,
  input  logic                          beat_ready_i,
  output logic                          beat_last_o,
  output logic [SP_W+OFF_W-1:0]         rd_idx_o,
  output logic                          release_o,
  output logic [SP_W-1:0]               release_sect_o
);
  drain_st_e        state_q;
  logic [SP_W-1:0]  rd_ptr_q, nxt;
  logic [OFF_W-1:0] rd_off_q;
  logic             cur_rdy, at_end, cont;

  assign nxt     = rd_ptr_q + SP_W'(1);
  assign cur_rdy = sect_occ_i[rd_ptr_q] && sect_closed_i[rd_ptr_q];
  assign at_end  = rd_off_q == sect_end_i[rd_ptr_q];
  // next ring sector belongs to the same write whenever the current one was not tail-sealed
  assign cont    = !sect_tail_i[rd_ptr_q] && sect_occ_i[nxt] && sect_closed_i[nxt];

  assign req_o          = state_q == DR_REQ;
  assign req_addr_o     = {sect_base_i[rd_ptr_q], sect_start_i[rd_ptr_q], {BYTE_W{1'b0}}};
  assign req_cmd_o      = xlate_cmd(sect_cmd_i[rd_ptr_q], dst_conv_i);
  assign beat_valid_o   = state_q == DR_DATA;
  assign beat_last_o    = at_end && !cont;
  assign rd_idx_o       = {rd_ptr_q, rd_off_q};
  assign release_o      = beat_valid_o && beat_ready_i && at_end;
  assign release_sect_o = rd_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= DR_IDLE;
      rd_ptr_q <= '0;
      rd_off_q <= '0;
    end else begin
      unique case (state_q)
        DR_IDLE: if (cur_rdy) begin
          state_q  <= DR_REQ;
          rd_off_q <= sect_start_i[rd_ptr_q];
        end
        DR_REQ: if (gnt_i) state_q <= DR_DATA;
        DR_DATA: if (beat_ready_i) begin
          if (at_end) begin
            rd_ptr_q <= nxt;
            if (cont) rd_off_q <= sect_start_i[nxt];
            else      state_q  <= DR_IDLE;
          end else begin
            rd_off_q <= rd_off_q + OFF_W'(1);
          end
        end
        default: state_q <= DR_IDLE;
      endcase
    end
  end

  AST_DRAIN_SEALED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != DR_IDLE |-> sect_occ_i[rd_ptr_q] && sect_closed_i[rd_ptr_q]); // R2
endmodule

// File: rtl/posted_wr_buf.sv
module posted_wr_buf import pwb_pkg::*; #(
  parameter int NUM_SECT   = 4,
  parameter int SECT_BYTES = 128,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  localparam int BE_W      = DATA_W / 8,
  localparam int BYTE_W    = $clog2(BE_W),
  localparam int BEATS     = SECT_BYTES / BE_W,
  localparam int OFF_W     = $clog2(BEATS),
  localparam int SP_W      = $clog2(NUM_SECT),
  localparam int HI_W      = ADDR_W - OFF_W - BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dst_conv_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [ADDR_W-1:0] in_addr_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic [BE_W-1:0]   in_be_i,
  input  logic              in_last_i,
  input  logic [3:0]        in_cmd_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [3:0]        req_cmd_o,
  input  logic              gnt_i,
  output logic              beat_valid_o,
  input  logic              beat_ready_i,
  output logic [DATA_W-1:0] beat_data_o,
  output logic [BE_W-1:0]   beat_be_o,
  output logic              beat_last_o
);
  logic                           wr_en, rel;
  logic [SP_W+OFF_W-1:0]          wr_idx, rd_idx;
  logic [SP_W-1:0]                rel_sect;
  logic [NUM_SECT-1:0]            occ, closed, tail;
  logic [NUM_SECT-1:0][OFF_W-1:0] start_off, end_off;
  logic [NUM_SECT-1:0][HI_W-1:0]  base;
  logic [NUM_SECT-1:0][3:0]       cmd;

  pwb_fill #(.NUM_SECT(NUM_SECT), .BEATS(BEATS), .HI_W(HI_W)) i_fill (
    .clk_i, .rst_ni, .in_valid_i,
    .in_waddr_i    (in_addr_i[ADDR_W-1:BYTE_W]),
    .in_last_i, .in_cmd_i, .in_ready_o,
    .wr_en_o       (wr_en),
    .wr_idx_o      (wr_idx),
    .release_i     (rel),
    .release_sect_i(rel_sect),
    .sect_occ_o    (occ),
    .sect_closed_o (closed),
    .sect_tail_o   (tail),
    .sect_start_o  (start_off),
    .sect_end_o    (end_off),
    .sect_base_o   (base),
    .sect_cmd_o    (cmd)
  );

  pwb_store #(.DEPTH(NUM_SECT * BEATS), .DATA_W(DATA_W)) i_store (
    .clk_i,
    .wr_en_i  (wr_en),
    .wr_idx_i (wr_idx),
    .wr_data_i(in_data_i),
    .wr_be_i  (in_be_i),
    .rd_idx_i (rd_idx),
    .rd_data_o(beat_data_o),
    .rd_be_o  (beat_be_o)
  );

  pwb_drain #(.NUM_SECT(NUM_SECT), .BEATS(BEATS), .HI_W(HI_W), .BYTE_W(BYTE_W)) i_drain (
    .clk_i, .rst_ni, .dst_conv_i,
    .sect_occ_i    (occ),
    .sect_closed_i (closed),
    .sect_tail_i   (tail),
    .sect_start_i  (start_off),
    .sect_end_i    (end_off),
    .sect_base_i   (base),
    .sect_cmd_i    (cmd),
    .req_o, .req_addr_o, .req_cmd_o, .gnt_i,
    .beat_valid_o, .beat_ready_i, .beat_last_o,
    .rd_idx_o      (rd_idx),
    .release_o     (rel),
    .release_sect_o(rel_sect)
  );

  AST_ALIGNED_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> in_addr_i[BYTE_W-1:0] == '0); // R2
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !gnt_i |=> req_o && $stable(req_addr_o) && $stable(req_cmd_o)); // R9
  AST_BEAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !beat_ready_i |=> beat_valid_o && $stable(beat_data_o) && $stable(beat_be_o)); // R9
  AST_CONV_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && dst_conv_i |-> req_cmd_o == CMD_MEM_WR); // R4
  AST_PHASE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_o && beat_valid_o)); // R9
endmodule

// File: tb/test_posted_wr_buf.sv
module test_posted_wr_buf;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        dst_conv_i = 1'b0, in_valid_i = 1'b0, in_last_i = 1'b0;
  logic [31:0] in_addr_i = '0, in_data_i = '0;
  logic [3:0]  in_be_i = '0, in_cmd_i = '0;
  logic        gnt_i = 1'b0, beat_ready_i = 1'b0;
  logic        in_ready_o, req_o, beat_valid_o, beat_last_o;
  logic [31:0] req_addr_o, beat_data_o;
  logic [3:0]  req_cmd_o, beat_be_o;
  int total = 0, bad = 0;

  always #5 clk_i = ~clk_i;

  posted_wr_buf i_posted_wr_buf (.*);

  typedef struct packed {
    logic [3:0]  cmd;
    logic        conv;
    logic [31:0] addr;
    logic [7:0]  n;
    logic [3:0]  xcmd;
  } vec_t;

  // R2 R3 R4 R7: single beat, mid-sector, full sector, crossing, two full sectors
  localparam vec_t VECS [6] = '{
    '{4'h7, 1'b0, 32'h0000_0100, 8'd1,  4'h7},
    '{4'hF, 1'b0, 32'h0000_0204, 8'd5,  4'hF},
    '{4'hF, 1'b1, 32'h0000_0300, 8'd32, 4'h7},
    '{4'h7, 1'b1, 32'h0000_3070, 8'd8,  4'h7},
    '{4'hF, 1'b1, 32'h0000_4000, 8'd64, 4'h7},
    '{4'h7, 1'b0, 32'h0000_5040, 8'd3,  4'h7}
  };

  function automatic logic [31:0] pat(logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction
  function automatic logic [3:0] bep(logic [31:0] a);
    return a[5:2];
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send_txn(logic [3:0] cmd, logic [31:0] addr, int n, bit end_last);
    for (int i = 0; i < n; i++) begin
      logic [31:0] a;
      a = addr + 32'(4 * i);
      in_valid_i = 1'b1; in_addr_i = a; in_data_i = pat(a); in_be_i = bep(a);
      in_last_i = end_last && (i == n - 1); in_cmd_i = cmd;
      while (!in_ready_o) @(negedge clk_i);
      @(negedge clk_i);
    end
    in_valid_i = 1'b0; in_last_i = 1'b0;
  endtask

  task automatic drain_burst(logic [31:0] addr, int n, logic [3:0] xcmd, string tag);
    int w = 0;
    while (!req_o && w < 300) begin @(negedge clk_i); w++; end
    chk(req_o, {tag, " req seen"}, 64'(req_o), 1);
    chk(req_addr_o == addr, {tag, " R2 req addr"}, 64'(req_addr_o), 64'(addr));
    chk(req_cmd_o == xcmd, {tag, " R4 req cmd"}, 64'(req_cmd_o), 64'(xcmd));
    repeat (2) @(negedge clk_i);
    chk(req_o && req_addr_o == addr, {tag, " R9 req held"}, 64'(req_addr_o), 64'(addr));
    gnt_i = 1'b1; @(negedge clk_i); gnt_i = 1'b0;
    beat_ready_i = 1'b1;
    for (int i = 0; i < n; i++) begin
      logic [31:0] a;
      a = addr + 32'(4 * i);
      if (i == 1) begin
        beat_ready_i = 1'b0; @(negedge clk_i);
        chk(beat_valid_o && beat_data_o == pat(a), {tag, " R9 beat held"}, 64'(beat_data_o), 64'(pat(a)));
        beat_ready_i = 1'b1;
      end
      chk(beat_valid_o && beat_data_o == pat(a), {tag, " R7 data"}, 64'(beat_data_o), 64'(pat(a)));
      chk(beat_be_o == bep(a), {tag, " R7 be"}, 64'(beat_be_o), 64'(bep(a)));
      chk(beat_last_o == (i == n - 1), {tag, " R3 R8 last"}, 64'(beat_last_o), 64'(i == n - 1));
      @(negedge clk_i);
    end
    beat_ready_i = 1'b0;
    chk(!beat_valid_o, {tag, " R3 burst ended"}, 64'(beat_valid_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!req_o && !beat_valid_o && in_ready_o, "R1 reset outputs", {req_o, beat_valid_o, in_ready_o}, 3'b001);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!req_o && !beat_valid_o && in_ready_o, "R1 after release", {req_o, beat_valid_o, in_ready_o}, 3'b001);

    foreach (VECS[k]) begin
      dst_conv_i = VECS[k].conv;
      send_txn(VECS[k].cmd, VECS[k].addr, int'(VECS[k].n), 1'b1);
      drain_burst(VECS[k].addr, int'(VECS[k].n), VECS[k].xcmd, $sformatf("vec%0d", k));
    end

    // R4: block write kept as-is toward a non-conventional destination already in table; plain write with conv
    dst_conv_i = 1'b0;

    // R3: write pauses at a boundary without end flag, so burst must stop there
    send_txn(4'h7, 32'h0000_2000, 32, 1'b0);
    drain_burst(32'h0000_2000, 32, 4'h7, "R3 stop");
    send_txn(4'h7, 32'h0000_2080, 4, 1'b1);
    drain_burst(32'h0000_2080, 4, 4'h7, "R3 remainder");

    // R5: non-memory writes dropped
    send_txn(4'h3, 32'h0000_0600, 2, 1'b1);
    send_txn(4'hB, 32'h0000_0700, 1, 1'b1);
    begin
      bit seen = 0;
      repeat (20) begin @(negedge clk_i); if (req_o) seen = 1; end
      chk(!seen, "R5 no request for io/cfg", 64'(seen), 0);
    end

    // R8: contiguous back-to-back transactions stay separate
    send_txn(4'h7, 32'h0000_8000, 3, 1'b1);
    send_txn(4'h7, 32'h0000_800C, 2, 1'b1);
    drain_burst(32'h0000_8000, 3, 4'h7, "R8 first");
    drain_burst(32'h0000_800C, 2, 4'h7, "R8 second");

    // R6: fill ring, then a new write must stall
    for (int s = 0; s < 4; s++) send_txn(4'h7, 32'h0000_7000 + 32'(s * 256), 1, 1'b1);
    in_valid_i = 1'b1; in_addr_i = 32'h0000_7400; in_cmd_i = 4'h7; in_last_i = 1'b1;
    in_data_i = pat(32'h0000_7400); in_be_i = bep(32'h0000_7400);
    repeat (2) @(negedge clk_i);
    chk(!in_ready_o, "R6 stall when ring full", 64'(in_ready_o), 0);
    fork
      send_txn(4'h7, 32'h0000_7400, 1, 1'b1);
      drain_burst(32'h0000_7000, 1, 4'h7, "R6 R8 order0");
    join
    for (int s = 1; s < 5; s++)
      drain_burst(32'h0000_7000 + 32'(s * 256), 1, 4'h7, $sformatf("R8 order%0d", s));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule